// File: doc/BRIEF.md
# Transmit Descriptor Auto-Poll Controller

This block sequences the suspended and running states of a DMA transmit engine. While the engine is suspended and a nonzero interval code is programmed, a prescaled timer counts out the interval that the code selects. When the interval ends, the block raises a fetch request that re-reads the ownership flag of the descriptor at the current list position. A DMA-owned result moves the engine to running. A host-owned result leaves it suspended and starts a fresh interval. Software can also force an immediate poll with a one-cycle demand strobe, and this works whether or not automatic polling is enabled.

Once running, the engine stays there until the transmit datapath reports that it has reached a host-owned descriptor. The block then drops back to suspended. Only one ownership read may be outstanding at a time. Descriptor parsing, address generation and frame transmission are handled by neighbouring logic.

Top module: `txpoll_ctrl`

## Requirements
- R1: During and after reset, `state_o` reads 0 (suspended, idle) and `fetch_req_o` is low. The `state_o` encoding is 0 = suspended idle, 1 = polling (fetch outstanding), 2 = running.
- R2: With `poll_code_i` = 0 and no demand strobe, the block never leaves state 0 on its own, however long it waits.
- R3: With `poll_code_i` = c (1..7) held steady in state 0, `state_o` becomes 1 exactly PRESCALE × BASE_TICKS × 2^(c-1) clock edges after the edge that started the interval. An interval starts on entry to state 0 or on a change of the code.
- R4: Any change of `poll_code_i` while in state 0 discards the elapsed part of the interval and restarts the count under the new code.
- R5: A high `demand_i` in state 0 moves the block to state 1 on the next edge, including when the code is 0.
- R6: `fetch_req_o` is high exactly while in state 1. It stays high for as long as `own_valid_i` is low.
- R7: In state 1, `own_valid_i` with `own_dma_i` = 1 moves the block to state 2. With `own_dma_i` = 0 it moves the block to state 0 and restarts the interval.
- R8: Only one poll may be outstanding. A demand strobe in state 1 or state 2 is ignored, and the timer raises no poll while in state 2.
- R9: `done_host_i` in state 2 returns the block to state 0, where a new interval starts. `done_host_i` outside state 2 and `own_valid_i` outside state 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_code_i | input | CODE_W | Automatic poll interval code; 0 disables automatic polling |
| demand_i | input | 1 | One-cycle manual poll demand |
| own_valid_i | input | 1 | Ownership result for the outstanding fetch is valid |
| own_dma_i | input | 1 | Ownership result: 1 = DMA owns the descriptor, 0 = host owns it |
| done_host_i | input | 1 | Running transmit process has met a host-owned descriptor |
| fetch_req_o | output | 1 | Request to read the ownership flag at the current list position |
| state_o | output | 2 | Process state: 0 suspended, 1 polling, 2 running |

## Verification
A timer that is off by one count, or that is not cleared on a code change or on re-entry, shows up as a polling edge one or more cycles away from the arithmetic product of prescale, base and the power of two. The bench therefore counts edges and compares them exactly for every code, both after a code change and after a host-owned reply. A state machine that accepts strobes in the wrong state shows at `state_o` on the very next edge, so each such strobe is followed by a sample one cycle later. A lost request shows as `fetch_req_o` falling without a reply.

// File: rtl/txpoll_pkg.sv
package txpoll_pkg;

  typedef enum logic [1:0] {
    ST_SUSP = 2'd0,
    ST_POLL = 2'd1,
    ST_RUN  = 2'd2
  } txp_state_e;

  // Number of prescaled ticks in one interval for a given code.
  // Code 0 yields 0 (disabled); code c yields base * 2^(c-1).
  function automatic int unsigned poll_ticks(input int unsigned code,
                                             input int unsigned base);
    if (code == 0) return 0;
    return base << (code - 1);
  endfunction

endpackage

// File: rtl/txpoll_prescaler.sv
module txpoll_prescaler #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  output logic tick
);

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = enable && !clear;
    end else begin : g_count
      localparam int unsigned PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pre_cnt;

      assign tick = enable && !clear && (pre_cnt == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
          pre_cnt <= '0;
        end else if (enable) begin
          if (pre_cnt == LAST) pre_cnt <= '0;
          else                 pre_cnt <= pre_cnt + 1'b1;
        end
      end

      // Ticks are at least PRESCALE cycles apart.
      assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

      assert_pre_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= LAST);
    end
  endgenerate

endmodule

// File: rtl/txpoll_interval.sv
module txpoll_interval #(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned BASE_TICKS = 2,
  parameter int unsigned TICK_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              expire
);

  logic [TICK_W-1:0] tick_cnt;
  logic [TICK_W-1:0] lim_m1;
  logic              code_on;

  always_comb begin
    lim_m1  = TICK_W'(txpoll_pkg::poll_ticks(int'(code), BASE_TICKS) - 1);
    code_on = (code != '0);
    expire  = code_on && tick && (tick_cnt == lim_m1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      tick_cnt <= '0;
    end else if (tick) begin
      if (expire) tick_cnt <= '0;
      else        tick_cnt <= tick_cnt + 1'b1;
    end
  end

  // Tick count never runs past the limit of the code in force.
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_on && !restart && !$past(restart)) |-> (tick_cnt <= lim_m1));

  // A restart always leaves the count empty.
  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tick_cnt == '0));

endmodule

// File: rtl/txpoll_fsm.sv
module txpoll_fsm
  import txpoll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       timer_expire,
  input  logic       demand_i,
  input  logic       own_valid_i,
  input  logic       own_dma_i,
  input  logic       done_host_i,
  output txp_state_e state,
  output logic       fetch_req
);

  txp_state_e state_nx;
  logic       poll_fire;

  always_comb begin
    poll_fire = (state == ST_SUSP) && (timer_expire || demand_i);
    state_nx  = state;
    unique case (state)
      ST_SUSP: if (poll_fire) state_nx = ST_POLL;
      ST_POLL: if (own_valid_i) state_nx = own_dma_i ? ST_RUN : ST_SUSP;
      ST_RUN:  if (done_host_i) state_nx = ST_SUSP;
      default: state_nx = ST_SUSP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_SUSP;
    else        state <= state_nx;
  end

  assign fetch_req = (state == ST_POLL);

  assert_demand_polls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP && demand_i) |=> (state == ST_POLL));

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL && !own_valid_i) |=> (state == ST_POLL && fetch_req));

  assert_dma_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL && own_valid_i && own_dma_i) |=> (state == ST_RUN));

  assert_host_suspends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL && own_valid_i && !own_dma_i) |=> (state == ST_SUSP));

  assert_run_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !done_host_i) |=> (state == ST_RUN));

  assert_done_suspends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && done_host_i) |=> (state == ST_SUSP));

endmodule

// File: rtl/txpoll_ctrl.sv
module txpoll_ctrl
  import txpoll_pkg::*;
#(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned PRESCALE   = 4,
  parameter int unsigned BASE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] poll_code_i,
  input  logic              demand_i,
  input  logic              own_valid_i,
  input  logic              own_dma_i,
  input  logic              done_host_i,
  output logic              fetch_req_o,
  output logic [1:0]        state_o
);

  localparam int unsigned MAX_CODE  = (1 << CODE_W) - 1;
  localparam int unsigned MAX_TICKS = poll_ticks(MAX_CODE, BASE_TICKS);
  localparam int unsigned TICK_W    = $clog2(MAX_TICKS + 1);

  logic [CODE_W-1:0] code_q;
  logic              code_change;
  logic              restart;
  logic              count_en;
  logic              tick;
  logic              timer_expire;
  txp_state_e        state;

  // Last code seen, to detect reprogramming.
  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= poll_code_i;
  end

  assign code_change = (poll_code_i != code_q);
  assign restart     = (state != ST_SUSP) || code_change;
  assign count_en    = (state == ST_SUSP) && (poll_code_i != '0);

  txpoll_prescaler #(
    .PRESCALE (PRESCALE)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (restart),
    .enable (count_en),
    .tick   (tick)
  );

  txpoll_interval #(
    .CODE_W     (CODE_W),
    .BASE_TICKS (BASE_TICKS),
    .TICK_W     (TICK_W)
  ) u_ival (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick),
    .code    (poll_code_i),
    .expire  (timer_expire)
  );

  txpoll_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .timer_expire (timer_expire),
    .demand_i     (demand_i),
    .own_valid_i  (own_valid_i),
    .own_dma_i    (own_dma_i),
    .done_host_i  (done_host_i),
    .state        (state),
    .fetch_req    (fetch_req_o)
  );

  assign state_o = state;

  assert_no_autopoll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && poll_code_i == '0 && !demand_i) |=> (state_o == 2'd0));

  assert_code_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && code_change && !demand_i) |=> (state_o == 2'd0));

  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0) |=> (state_o != 2'd1 || $past(state_o) == 2'd1));

endmodule

// File: tb/txpoll_ctrl_test.sv
`timescale 1ns/1ps
module txpoll_ctrl_test;

  localparam int unsigned CODE_W = 3;
  localparam int unsigned PRE    = 4;
  localparam int unsigned BASE   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CODE_W-1:0] poll_code = '0;
  logic              demand = 1'b0;
  logic              own_valid = 1'b0;
  logic              own_dma = 1'b0;
  logic              done_host = 1'b0;
  logic              fetch_req;
  logic [1:0]        state;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  txpoll_ctrl #(.CODE_W(CODE_W), .PRESCALE(PRE), .BASE_TICKS(BASE)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_code_i (poll_code),
    .demand_i    (demand),
    .own_valid_i (own_valid),
    .own_dma_i   (own_dma),
    .done_host_i (done_host),
    .fetch_req_o (fetch_req),
    .state_o     (state)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_cycles(input int c);
    return PRE * BASE * (1 << (c - 1));
  endfunction

  // Counts negedges until the block leaves state 0; strobes cleared each time.
  task automatic measure(output int n);
    n = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      demand = 0; own_valid = 0; done_host = 0;
      n++;
      if (state != 2'd0) break;
    end
  endtask

  task automatic step();
    @(negedge clk);
    demand = 0; own_valid = 0; done_host = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    bit ok;
    repeat (3) @(negedge clk);
    check(state == 2'd0 && !fetch_req, "R1 in reset", state, 0);
    rst_n = 1'b1;
    step();
    check(state == 2'd0 && !fetch_req, "R1 after reset", state, 0);

    // R2: code 0 never polls
    ok = 1;
    for (int k = 0; k < 600; k++) begin step(); if (state != 2'd0) ok = 0; end
    check(ok, "R2 no auto poll with code 0", state, 0);

    // R5: demand with code 0
    demand = 1; step();
    check(state == 2'd1 && fetch_req, "R5 demand polls", state, 1);
    // R6: request held
    repeat (5) step();
    check(state == 2'd1 && fetch_req, "R6 fetch held", fetch_req, 1);
    // R8: demand while polling ignored
    demand = 1; step();
    check(state == 2'd1, "R8 demand in polling", state, 1);
    own_valid = 1; own_dma = 0; step();
    check(state == 2'd0 && !fetch_req, "R7 host reply suspends", state, 0);

    // R3 / R7: sweep codes
    for (int c = 1; c <= 7; c++) begin
      poll_code = CODE_W'(c);
      measure(n);
      check(n == exp_cycles(c) + 1, "R3 interval after code change", n, exp_cycles(c) + 1);
      check(fetch_req == 1'b1, "R6 request on poll", fetch_req, 1);
      own_valid = 1; own_dma = 0;
      measure(n);
      check(n == exp_cycles(c) + 1, "R7 interval restarts after host reply", n, exp_cycles(c) + 1);
      own_valid = 1; own_dma = 0; step();
      check(state == 2'd0, "R7 back to suspended", state, 0);
    end

    // R4: code change mid-interval
    poll_code = 3'd3;
    repeat (20) step();
    check(state == 2'd0, "R4 still counting", state, 0);
    poll_code = 3'd2;
    measure(n);
    check(n == exp_cycles(2) + 1, "R4 restart on code change", n, exp_cycles(2) + 1);
    own_valid = 1; own_dma = 0; step();

    // R7 / R8 / R9: running path
    poll_code = 3'd1;
    measure(n);
    check(n == exp_cycles(1) + 1, "R3 code 1 interval", n, exp_cycles(1) + 1);
    own_valid = 1; own_dma = 1; step();
    check(state == 2'd2 && !fetch_req, "R7 dma reply runs", state, 2);
    ok = 1;
    for (int k = 0; k < 600; k++) begin step(); if (state != 2'd2 || fetch_req) ok = 0; end
    check(ok, "R8 no timer poll while running", state, 2);
    demand = 1; step();
    check(state == 2'd2, "R8 demand in running", state, 2);
    own_valid = 1; own_dma = 0; step();
    check(state == 2'd2, "R9 own_valid in running ignored", state, 2);
    done_host = 1;
    measure(n);
    check(n == exp_cycles(1) + 1, "R9 done suspends and restarts interval", n, exp_cycles(1) + 1);
    own_valid = 1; own_dma = 0; step();

    // R9: strobes ignored in suspended
    poll_code = 3'd0; step();
    done_host = 1; step();
    check(state == 2'd0, "R9 done in suspended ignored", state, 0);
    own_valid = 1; own_dma = 1; step();
    check(state == 2'd0, "R9 own_valid in suspended ignored", state, 0);
    ok = 1;
    for (int k = 0; k < 100; k++) begin step(); if (state != 2'd0) ok = 0; end
    check(ok, "R2 idle stays suspended", state, 0);

    // R5: demand mid-interval with nonzero code
    poll_code = 3'd7;
    repeat (10) step();
    demand = 1; step();
    check(state == 2'd1 && fetch_req, "R5 demand mid-interval", state, 1);
    own_valid = 1; own_dma = 0; step();
    check(state == 2'd0, "R7 final host reply", state, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule